// File: doc/BRIEF.md
# Indirect SRAM programming port

This block lets a serial host load and read back the code memory of an embedded processor through only two byte registers. The control register selects the operation. The data window register streams bytes into or out of memory through an address pointer that advances by one on its own after each access. The host never sends a memory address. It clears the pointer, picks the direction and the target array, then writes or reads the window once per byte. Each code byte has a matching parity bit, kept in a second array that the same window can reach.

Three of the control bits drive the processor directly. One holds it in reset, one lets it execute from the SRAM as well as its ROM, and one turns on parity checking of its fetches. The processor fetch port reads the code array. With checking on, it raises a sticky error flag when a fetched byte disagrees with its stored parity bit.

Top module: `sram_prog_port`

## Requirements
- R1: After reset the control register reads 0x00. cpu_rst, ram_en, par_chk_en, par_err, bus_rdata and fetch_data are all 0.
- R2: A write to the control address (0x60) stores the byte, and a read returns it with bit 5 forced to 0. Read data appears on bus_rdata in the cycle after the read strobe. A read of any address other than 0x60 and 0x61 returns 0x00.
- R3: cpu_rst follows control bit 6, par_chk_en follows bit 4 and ram_en follows bit 3. Setting and clearing bit 6 changes no other control bit and does not move the pointer.
- R4: With bit 7 = 1, bit 2 = 0 and bit 1 = 0, a write to the window (0x61) stores the byte in the code array at the pointer. It stores the XOR of the byte's eight bits in the parity array at the same address, and the pointer advances by one.
- R5: With bit 7 = 1 and bit 1 = 1, a read of the window returns the code byte at the pointer when bit 2 = 0. When bit 2 = 1 it returns the parity bit in bit 0, with bits 7..1 = 0. Either read advances the pointer by one.
- R6: With bit 7 = 1, bit 2 = 1 and bit 1 = 0, a window write stores bit 0 of the byte in the parity array only. The code array is left unchanged.
- R7: A window access made while bit 7 = 0, or in the direction bit 1 does not select, changes no memory and does not advance the pointer. A blocked window read returns 0x00.
- R8: While control bit 0 = 1, window accesses use address 0 and the pointer does not advance. Once the bit returns to 0, streaming starts at address 0. After the last address the pointer wraps to 0.
- R9: A bus_stop pulse, with no read in the same cycle, clears bus_rdata to 0x00 in the next cycle. The pointer keeps its value, so the next access continues at the following address.
- R10: A fetch_en pulse puts the code byte at fetch_addr on fetch_data in the next cycle when ram_en = 1. When ram_en = 0 it puts 0x00 there.
- R11: A fetch with ram_en = 1 and par_chk_en = 1 whose stored parity bit differs from the XOR of the code byte sets par_err in the next cycle. par_err then stays set while par_chk_en = 1, and clears in the cycle after par_chk_en is seen at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address of the host access |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_rd | input | 1 | Host read strobe, one cycle per byte |
| bus_wdata | input | 8 | Host write data |
| bus_stop | input | 1 | Pulse marking the end of a host transaction |
| bus_rdata | output | 8 | Host read data, registered |
| cpu_rst | output | 1 | Holds the processor in reset |
| ram_en | output | 1 | Lets the processor execute from SRAM as well as ROM |
| par_chk_en | output | 1 | Enables parity checking of fetches |
| fetch_en | input | 1 | Processor fetch request |
| fetch_addr | input | ADDR_W | Processor fetch address |
| fetch_data | output | 8 | Fetched code byte, registered |
| par_err | output | 1 | Sticky parity error flag |

## Verification
The parity error is the hardest state to reach from the ports. Every code write through the window also stores a matching parity bit, so the two arrays never disagree on their own. The stimulus first loads the whole code array. It then switches the window to the parity array and overwrites a chosen set of addresses with inverted bits. Finally it sweeps processor fetches over every address, so the flag is seen to stay clear, set at the first bad address, stay set, and clear once checking is turned off.

// File: rtl/spp_pkg.sv
package spp_pkg;

  localparam int BYTE_W = 8;
  localparam int REG_AW = 8;

  typedef struct packed {
    logic prog_sel;
    logic cpu_hold;
    logic rsvd;
    logic par_chk;
    logic ram_on;
    logic par_sel;
    logic rd_dir;
    logic ptr_clr;
  } ctrl_t;

  localparam logic [BYTE_W-1:0] CTRL_WMASK = 8'hDF;

  function automatic logic even_par(input logic [BYTE_W-1:0] d);
    return ^d;
  endfunction

  function automatic logic [BYTE_W-1:0] ctrl_filter(input logic [BYTE_W-1:0] d);
    return d & CTRL_WMASK;
  endfunction

endpackage

// File: rtl/spp_ctrl_reg.sv
module spp_ctrl_reg
  import spp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic [BYTE_W-1:0] ctrl_byte
);

  logic [BYTE_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_filter(wdata);
  end

  assign ctrl      = ctrl_t'(ctrl_q);
  assign ctrl_byte = ctrl_q;

  // R2: a write lands with bit 5 cleared
  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_byte == ($past(wdata) & 8'hDF));

  // R3: no write, no change
  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_byte));

endmodule

// File: rtl/spp_addr_ptr.sv
module spp_addr_ptr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr
);

  logic [ADDR_W-1:0] ptr_q;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr_q <= '0;
    else if (clr) ptr_q <= '0;
    else if (adv) ptr_q <= step(ptr_q);
  end

  assign ptr = clr ? '0 : ptr_q;

  // R8: clear holds the stored pointer at zero
  assert_ptr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr_q == '0);

  // R4: an accepted access moves the pointer by exactly one (wrapping)
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> ptr_q == $past(ptr_q) + ADDR_W'(1));

  // R7: without an accepted access the pointer stays put
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(ptr_q));

endmodule

// File: rtl/spp_mem.sv
module spp_mem
  import spp_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we_code,
  input  logic              host_we_par,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rcode,
  output logic              host_rpar,
  input  logic              fetch_en,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              ram_on,
  input  logic              par_chk,
  output logic [BYTE_W-1:0] fetch_data,
  output logic              par_err
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] code_q [DEPTH];
  logic [DEPTH-1:0]  par_q;

  // host side: one array written per access
  always_ff @(posedge clk) begin
    if (host_we_code) begin
      code_q[host_addr] <= host_wdata;
      par_q[host_addr]  <= even_par(host_wdata);
    end else if (host_we_par) begin
      par_q[host_addr]  <= host_wdata[0];
    end
  end

  assign host_rcode = code_q[host_addr];
  assign host_rpar  = par_q[host_addr];

  // processor side
  logic [BYTE_W-1:0] fetch_word;
  logic              fetch_bad;

  assign fetch_word = code_q[fetch_addr];
  assign fetch_bad  = fetch_en && ram_on && par_chk &&
                      (even_par(fetch_word) != par_q[fetch_addr]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_data <= '0;
    end else if (fetch_en) begin
      fetch_data <= ram_on ? fetch_word : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         par_err <= 1'b0;
    else if (!par_chk)  par_err <= 1'b0;
    else if (fetch_bad) par_err <= 1'b1;
  end

  // R4: a code write leaves matching parity behind
  assert_par_gen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_we_code |=> par_q[$past(host_addr)] == even_par($past(host_wdata)));

  // R6: a parity write takes bit 0 of the byte
  assert_par_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_we_par && !host_we_code |=> par_q[$past(host_addr)] == $past(host_wdata[0]));

  // R10: no SRAM execution means a zero fetch
  assert_fetch_rom_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !ram_on) |=> fetch_data == '0);

  // R11: mismatch sets, flag is sticky, disable clears
  assert_err_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_bad |=> par_err);
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && par_chk) |=> par_err);
  assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !par_chk |=> !par_err);

endmodule

// File: rtl/sram_prog_port.sv
module sram_prog_port
  import spp_pkg::*;
#(
  parameter int               ADDR_W    = 6,
  parameter logic [REG_AW-1:0] CTRL_ADDR = 8'h60,
  parameter logic [REG_AW-1:0] WIN_ADDR  = 8'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_stop,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              cpu_rst,
  output logic              ram_en,
  output logic              par_chk_en,
  input  logic              fetch_en,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [BYTE_W-1:0] fetch_data,
  output logic              par_err
);

  ctrl_t             ctrl;
  logic [BYTE_W-1:0] ctrl_byte;
  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] mem_rcode;
  logic              mem_rpar;

  // decoded events, kept as named wires
  logic ctrl_wr_hit, ctrl_rd_hit, win_wr_hit, win_rd_hit;
  logic win_wr_ok, win_rd_ok, ptr_adv;

  assign ctrl_wr_hit = bus_wr && (bus_addr == CTRL_ADDR);
  assign ctrl_rd_hit = bus_rd && (bus_addr == CTRL_ADDR);
  assign win_wr_hit  = bus_wr && (bus_addr == WIN_ADDR);
  assign win_rd_hit  = bus_rd && (bus_addr == WIN_ADDR);
  assign win_wr_ok   = win_wr_hit && ctrl.prog_sel && !ctrl.rd_dir;
  assign win_rd_ok   = win_rd_hit && ctrl.prog_sel &&  ctrl.rd_dir;
  assign ptr_adv     = win_wr_ok || win_rd_ok;

  spp_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_wr_hit),
    .wdata     (bus_wdata),
    .ctrl      (ctrl),
    .ctrl_byte (ctrl_byte)
  );

  spp_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctrl.ptr_clr),
    .adv   (ptr_adv),
    .ptr   (ptr)
  );

  spp_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr    (ptr),
    .host_we_code (win_wr_ok && !ctrl.par_sel),
    .host_we_par  (win_wr_ok &&  ctrl.par_sel),
    .host_wdata   (bus_wdata),
    .host_rcode   (mem_rcode),
    .host_rpar    (mem_rpar),
    .fetch_en     (fetch_en),
    .fetch_addr   (fetch_addr),
    .ram_on       (ctrl.ram_on),
    .par_chk      (ctrl.par_chk),
    .fetch_data   (fetch_data),
    .par_err      (par_err)
  );

  function automatic logic [BYTE_W-1:0] win_value(input logic sel_par,
                                                  input logic [BYTE_W-1:0] code,
                                                  input logic par);
    return sel_par ? {{(BYTE_W-1){1'b0}}, par} : code;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (ctrl_rd_hit)    bus_rdata <= ctrl_byte;
      else if (win_rd_ok) bus_rdata <= win_value(ctrl.par_sel, mem_rcode, mem_rpar);
      else                bus_rdata <= '0;
    end else if (bus_stop) begin
      bus_rdata <= '0;
    end
  end

  assign cpu_rst    = ctrl.cpu_hold;
  assign ram_en     = ctrl.ram_on;
  assign par_chk_en = ctrl.par_chk;

  // R7: a blocked window read yields zero
  assert_blocked_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd_hit && !ctrl.prog_sel) |=> bus_rdata == '0);

  // R7: a window write with program select low leaves the pointer alone
  assert_blocked_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr_hit && !ctrl.prog_sel && !ctrl.ptr_clr && !bus_rd) |=> $stable(ptr));

  // R9: stop clears the read holding register
  assert_stop_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop && !bus_rd) |=> bus_rdata == '0);

  // R3: cpu reset output mirrors the register across its changes only
  assert_cpu_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr_hit |=> $stable(cpu_rst));

endmodule

// File: tb/tb_sram_prog_port.sv
module tb_sram_prog_port;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [7:0] CA = 8'h60;
  localparam logic [7:0] WA = 8'h61;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_stop = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic cpu_rst, ram_en, par_chk_en, par_err;
  logic fetch_en = 1'b0;
  logic [ADDR_W-1:0] fetch_addr = '0;
  logic [7:0] fetch_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sram_prog_port #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_stop(bus_stop),
    .bus_rdata(bus_rdata), .cpu_rst(cpu_rst), .ram_en(ram_en),
    .par_chk_en(par_chk_en), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
    .fetch_data(fetch_data), .par_err(par_err)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) % 256);
  endfunction

  function automatic bit ones_odd(input logic [7:0] v);
    int c = 0;
    for (int b = 0; b < 8; b++) c += int'(v[b]);
    return (c % 2) == 1;
  endfunction

  function automatic bit bent(input int i);
    return (i % 5) == 3;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic fetch(input int a);
    @(negedge clk);
    fetch_en = 1'b1; fetch_addr = ADDR_W'(a);
    @(negedge clk);
    fetch_en = 1'b0;
  endtask

  task automatic restart(input logic [7:0] mode);
    wr(CA, mode | 8'h01);
    wr(CA, mode);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] exp8;
    bit err_exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {cpu_rst, ram_en, par_chk_en, par_err}, 4'b0);
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 fetch_data", fetch_data, 8'h00);
    rd(CA, r);
    chk("R1 ctrl", r, 8'h00);

    // R2/R3 full sweep of control values
    for (int v = 0; v < 256; v++) begin
      wr(CA, 8'(v));
      chk("R3 pins", {cpu_rst, par_chk_en, ram_en}, {v[6], v[4], v[3]});
      rd(CA, r);
      chk("R2 readback", r, 8'(v) & 8'hDF);
    end
    rd(8'h62, r);
    chk("R2 unmapped", r, 8'h00);
    wr(CA, 8'h00);

    // R4 load all code bytes
    restart(8'h80);
    for (int i = 0; i < DEPTH; i++) wr(WA, pat(i));
    // R5 read code back
    restart(8'h82);
    for (int i = 0; i < DEPTH; i++) begin
      rd(WA, r);
      chk("R5 code", r, pat(i));
    end
    // R4/R5 parity generated on write
    restart(8'h86);
    for (int i = 0; i < DEPTH; i++) begin
      rd(WA, r);
      chk("R4 parity", r, {7'b0, ones_odd(pat(i))});
    end

    // R6 overwrite parity, inverting selected entries
    restart(8'h84);
    for (int i = 0; i < DEPTH; i++)
      wr(WA, {7'b0, ones_odd(pat(i)) ^ bent(i)});
    restart(8'h82);
    for (int i = 0; i < DEPTH; i++) begin
      rd(WA, r);
      chk("R6 code kept", r, pat(i));
    end
    restart(8'h86);
    for (int i = 0; i < DEPTH; i++) begin
      rd(WA, r);
      chk("R6 parity", r, {7'b0, ones_odd(pat(i)) ^ bent(i)});
    end

    // R10/R11 fetch sweep with checking on
    wr(CA, 8'h18);
    err_exp = 0;
    for (int i = 0; i < DEPTH; i++) begin
      fetch(i);
      err_exp = err_exp | bent(i);
      chk("R10 fetch", fetch_data, pat(i));
      chk("R11 sticky", par_err, err_exp);
    end
    wr(CA, 8'h08);
    @(negedge clk);
    chk("R11 clear", par_err, 1'b0);
    wr(CA, 8'h18);
    fetch(1);
    chk("R11 clean fetch", par_err, 1'b0);
    wr(CA, 8'h10);
    fetch(3);
    chk("R10 rom only", fetch_data, 8'h00);
    chk("R11 no check without ram", par_err, 1'b0);

    // R7 blocked accesses
    restart(8'h80);
    rd(WA, r);
    chk("R7 wrong dir read", r, 8'h00);
    wr(CA, 8'h82);
    rd(WA, r);
    chk("R7 no advance", r, pat(0));
    restart(8'h82);
    wr(WA, 8'hAA);
    rd(WA, r);
    chk("R7 wrong dir write", r, pat(0));
    restart(8'h00);
    wr(WA, 8'h55);
    rd(WA, r);
    chk("R7 prog off read", r, 8'h00);
    restart(8'h82);
    rd(WA, r);
    chk("R7 prog off write", r, pat(0));

    // R3 cpu reset toggle keeps pointer
    rd(WA, r);
    chk("R5 stream", r, pat(1));
    wr(CA, 8'hC2);
    chk("R3 cpu hold", cpu_rst, 1'b1);
    rd(CA, r);
    chk("R3 other bits", r, 8'hC2);
    wr(CA, 8'h82);
    chk("R3 cpu release", cpu_rst, 1'b0);
    rd(WA, r);
    chk("R3 pointer kept", r, pat(2));

    // R9 stop
    rd(WA, r);
    chk("R9 before stop", r, pat(3));
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
    chk("R9 rdata cleared", bus_rdata, 8'h00);
    rd(WA, r);
    chk("R9 pointer kept", r, pat(4));

    // R8 clear held, then wrap
    wr(CA, 8'h81);
    wr(WA, 8'h5A);
    wr(WA, 8'hA5);
    wr(CA, 8'h83);
    rd(WA, r);
    chk("R8 held a", r, 8'hA5);
    rd(WA, r);
    chk("R8 held b", r, 8'hA5);
    wr(CA, 8'h82);
    for (int i = 0; i <= DEPTH; i++) begin
      rd(WA, r);
      exp8 = (i % DEPTH == 0) ? 8'hA5 : pat(i);
      chk("R8 stream/wrap", r, exp8);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule